// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is an on-chip synchronous static memory whose bus never needs an idle cycle between a read and a write. A command (address, direction, byte masks, selection) is registered on a rising clock edge. The data for that command moves in the clock cycle that follows. Reads are flow-through: during the data cycle the array output goes straight to the data pins, with no output register. Write data is sampled at the edge that closes the data cycle. A following read of the same word therefore sees the new contents.

A load cycle takes a fresh external address. An advance cycle steps a 2-bit burst counter instead, so one address yields up to four words, in linear or interleaved order. An active-high clock-enable-off input freezes every internal register. Three chip enables of mixed polarity gate new commands only. The tri-state bus is modelled as separate in, out and output-enable signals. The asynchronous output enable can switch the driver off at any instant.

Top module: `zbt_sram`

## Requirements
- R1: A command captured at a rising edge has its data phase in the next cycle. A read word appears on `dq_out` in that cycle. A write stores the `dq_in` value present at the enabled edge that ends that cycle.
- R2: Reads and writes may be issued on consecutive cycles in any mix with no idle cycle. A read issued in the cycle right after a write to the same word returns the newly written value.
- R3: During a read data phase, `dq_oe` is high whenever `oe_n` is low. `dq_out` then holds the addressed word, taken straight from the array.
- R4: While `clk_en_n` is high, every other synchronous input is ignored and all state holds: the pending operation, its address, the burst position and the array. A read data phase stays on the bus. A pending write commits only at the next edge with `clk_en_n` low, using the `dq_in` present at that edge.
- R5: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A load cycle (`adv_ld`=0) without selection starts no operation. A transfer issued in the previous cycle still completes.
- R6: `dq_oe` is low in the cycle after a deselected load, in the cycle after a write command, in any cycle without a read data phase, and after reset.
- R7: With `linear_order`=1, each advance adds 1 modulo 4 to address bits [1:0] and keeps the upper bits of the loaded address.
- R8: With `linear_order`=0, the k-th advance after a load gives address bits [1:0] equal to the loaded bits [1:0] XOR k (k modulo 4), with the upper bits kept.
- R9: An advance cycle keeps the direction and selection of the loading command, ignoring `we_n` (1 = read, 0 = write) and the chip enables.
- R10: `bw_n` is sampled with each command or advance cycle. Bit i low lets the write update lane i, bits [9i+8:9i]. Bit i high leaves that lane's stored contents unchanged.
- R11: `oe_n` acts without a clock. Raising it drops `dq_oe` at once, and lowering it during a read data phase restores the drive at once. It has no effect on stored data or on the pipeline.
- R12: An advance cycle with no operation in progress (after reset or a deselected load) starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| clk_en_n | input | 1 | High freezes the device for the cycle |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| we_n | input | 1 | Direction of a load: 1 = read, 0 = write |
| bw_n | input | 4 | Active-low byte-lane write masks |
| linear_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | 6 | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | 36 | Data bus, inward direction |
| dq_out | output | 36 | Data bus, outward direction (flow-through) |
| dq_oe | output | 1 | High when the device drives the bus |

## Verification
The sharpest collision is the commit of a write's data on the same edge that captures a read of that same word. The bench provokes it with write/read pairs on consecutive cycles, some to one address and some to two. The scoreboard expects the read to return the freshly committed value. A second collision puts a stall inside a data phase. The bench drives junk commands and junk `dq_in` during a frozen cycle. It expects the read word to stay on the bus one more cycle, or the write to land with the data of the later enabled edge. Read-back then shows that nothing from the junk reached the array.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } zbt_op_e;

   // low address bits of a burst beat: linear adds, interleaved xors
   function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       linear);
      return linear ? (start + beat) : (start ^ beat);
   endfunction

endpackage

// File: rtl/zbt_lane_ram.sv
module zbt_lane_ram #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] rdata
);
   localparam int WORDS = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wdata;
   end

   // flow-through read: no output register
   assign rdata = mem[addr];

endmodule

// File: rtl/zbt_cmd_seq.sv
module zbt_cmd_seq
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic              adv,
   input  logic              rd,
   input  logic              sel,
   input  logic              linear,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  bw_n,
   output zbt_op_e           op_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LANES-1:0]  bw_q
);
   zbt_op_e           op_d;
   logic [ADDR_W-1:0] base_q, base_d, addr_d;
   logic [1:0]        beat_q, beat_d;

   always_comb begin
      op_d   = op_q;
      base_d = base_q;
      beat_d = beat_q;
      addr_d = addr_q;
      if (!adv) begin
         op_d   = sel ? (rd ? OP_READ : OP_WRITE) : OP_IDLE;
         base_d = addr;
         beat_d = 2'd0;
         addr_d = addr;
      end else if (op_q != OP_IDLE) begin
         beat_d = beat_q + 2'd1;
         addr_d = {base_q[ADDR_W-1:2], burst_lsb(base_q[1:0], beat_d, linear)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         base_q <= '0;
         beat_q <= '0;
         addr_q <= '0;
         bw_q   <= '1;
      end else if (!stall) begin
         op_q   <= op_d;
         base_q <= base_d;
         beat_q <= beat_d;
         addr_q <= addr_d;
         bw_q   <= bw_n;
      end
   end

   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(op_q) && $stable(addr_q) && $stable(bw_q));

   // R5
   desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !adv && !sel) |=> (op_q == OP_IDLE));

   // R12
   idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && adv && op_q == OP_IDLE) |=> (op_q == OP_IDLE));

   // R9
   dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && adv && op_q != OP_IDLE) |=> (op_q == $past(op_q)));

   // R7
   lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && adv && op_q != OP_IDLE && linear) |=>
         (addr_q[1:0] == 2'($past(addr_q[1:0]) + 2'd1)) &&
         (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2])));

   // R8
   ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && adv && op_q != OP_IDLE && !linear) |=>
         ((addr_q[1:0] ^ base_q[1:0]) == 2'($past(addr_q[1:0] ^ base_q[1:0]) + 2'd1)));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
   import zbt_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clk_en_n,
   input  logic                         ce1_n,
   input  logic                         ce2,
   input  logic                         ce3_n,
   input  logic                         adv_ld,
   input  logic                         we_n,
   input  logic [LANES-1:0]             bw_n,
   input  logic                         linear_order,
   input  logic [$clog2(DEPTH)-1:0]     addr,
   input  logic                         oe_n,
   input  logic [LANES*LANE_W-1:0]      dq_in,
   output logic [LANES*LANE_W-1:0]      dq_out,
   output logic                         dq_oe
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int DATA_W = LANES * LANE_W;

   if (DEPTH < 4 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("zbt_sram: DEPTH must be a power of two of at least 4");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("zbt_sram: LANES and LANE_W must be positive");
   end

   logic              sel;
   zbt_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LANES-1:0]  bw_q;

   assign sel = ~ce1_n & ce2 & ~ce3_n;

   zbt_cmd_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall  (clk_en_n),
      .adv    (adv_ld),
      .rd     (we_n),
      .sel    (sel),
      .linear (linear_order),
      .addr   (addr),
      .bw_n   (bw_n),
      .op_q   (op_q),
      .addr_q (addr_q),
      .bw_q   (bw_q)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic lane_we;
      assign lane_we = (op_q == OP_WRITE) & ~clk_en_n & ~bw_q[g];
      zbt_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
         .clk   (clk),
         .wr_en (lane_we),
         .addr  (addr_q),
         .wdata (dq_in[g*LANE_W +: LANE_W]),
         .rdata (dq_out[g*LANE_W +: LANE_W])
      );
   end

   assign dq_oe = (op_q == OP_READ) & ~oe_n;

   // R6
   wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld && sel && !we_n) |=> !dq_oe);

   // R5
   desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld && !sel) |=> !dq_oe);

endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
   localparam int CLK_P = 10;
   localparam int AW    = 6;
   localparam int DW    = 36;
   localparam logic [2:0] SEL = 3'b010; // {ce1_n, ce2, ce3_n}

   typedef struct {
      int          due;
      logic [DW-1:0] data;
      string       req;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic clk_en_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
   logic adv_ld = 1'b0, we_n = 1'b1, lin = 1'b1, oe_n = 1'b0;
   logic [3:0] bw_n = 4'hF;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic dq_oe;

   int cyc = 0, n_chk = 0, n_fail = 0, wcnt = 0;
   bit run = 0;
   exp_t q[$];
   logic [DW-1:0] ref_mem [1 << AW];

   // bench model of the command state
   int m_op = 0;              // 0 idle, 1 read, 2 write
   logic [AW-1:0] m_base = '0, m_cur = '0;
   logic [1:0] m_cnt = '0;
   bit pend_wr = 0;
   logic [AW-1:0] pend_addr = '0;
   logic [3:0] pend_bw = '1;
   logic [DW-1:0] pend_data = '0;

   zbt_sram u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2),
      .ce3_n(ce3_n), .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n),
      .linear_order(lin), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] gen(input int n);
      logic [8:0] b;
      b = 9'(n * 53 + 7);
      return {b, ~b, b ^ 9'h0A5, 9'(b + 9'd77)};
   endfunction

   // one clock of stimulus; the command is captured at the next rising edge
   task automatic drv(input bit stall, input bit adv, input bit rd, input int a,
                      input logic [3:0] bwn, input logic [2:0] ce, input string req);
      exp_t nq[$];
      exp_t e;
      bit sel;
      @(posedge clk); #1;
      if (!stall) begin
         if (pend_wr) begin
            dq_in = pend_data;
            for (int l = 0; l < 4; l++)
               if (!pend_bw[l]) ref_mem[pend_addr][l*9 +: 9] = pend_data[l*9 +: 9];
            pend_wr = 0;
         end else dq_in = gen(cyc + 1000);
         sel = (ce == SEL);
         if (!adv) begin
            m_op = sel ? (rd ? 1 : 2) : 0;
            m_base = AW'(a);
            m_cnt = 2'd0;
            m_cur = AW'(a);
         end else if (m_op != 0) begin
            m_cnt = m_cnt + 2'd1;
            m_cur = {m_base[AW-1:2], lin ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
         end
         if (m_op == 1) q.push_back('{due: cyc + 1, data: ref_mem[m_cur], req: req});
         if (m_op == 2) begin
            wcnt++;
            pend_wr = 1; pend_addr = m_cur; pend_bw = bwn; pend_data = gen(wcnt);
         end
      end else begin
         dq_in = ~pend_data ^ 36'h5A5A5A5A5;
         foreach (q[i]) begin
            e = q[i];
            if (e.due == cyc) begin
               nq.push_back(e);
               e.due = cyc + 1;
               nq.push_back(e);
            end else begin
               if (e.due > cyc) e.due++;
               nq.push_back(e);
            end
         end
         q = nq;
      end
      clk_en_n = stall; adv_ld = adv; we_n = rd; addr = AW'(a); bw_n = bwn;
      {ce1_n, ce2, ce3_n} = ce;
   endtask

   task automatic wr(input int a, input string req);
      drv(0, 0, 0, a, 4'h0, SEL, req);
   endtask
   task automatic rdc(input int a, input string req);
      drv(0, 0, 1, a, 4'hF, SEL, req);
   endtask
   task automatic nop(input string req);
      drv(0, 0, 1, 0, 4'hF, 3'b110, req);
   endtask

   // scoreboard monitor, samples away from the rising edge
   always @(negedge clk) begin
      if (rst_n && run) begin
         exp_t e;
         while (q.size() > 0 && q[0].due < cyc) begin
            e = q.pop_front();
            chk(0, e.req, "read word never presented", '0, e.data);
         end
         if (q.size() > 0 && q[0].due == cyc) begin
            e = q.pop_front();
            chk(dq_oe === !oe_n, e.req, "drive enable in read phase", {35'd0, dq_oe}, {35'd0, !oe_n});
            if (!oe_n) chk(dq_out === e.data, e.req, "read data", dq_out, e.data);
         end else begin
            chk(dq_oe === 1'b0, "R6", "bus released outside read phase", {35'd0, dq_oe}, '0);
         end
      end
   end

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] keep;
      for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
      repeat (3) @(posedge clk);
      #2;
      chk(dq_oe === 1'b0, "R6", "bus off in reset", {35'd0, dq_oe}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dq_oe === 1'b0, "R6", "bus off after reset", {35'd0, dq_oe}, '0);
      run = 1;

      // R12: advance right after reset starts nothing
      drv(0, 1, 0, 5, 4'h0, SEL, "R12");
      drv(0, 1, 1, 5, 4'h0, SEL, "R12");

      // R1: fill a block of words, then read them back
      for (int i = 0; i < 64; i++) wr(i, "R1");
      for (int i = 0; i < 8; i++) rdc(i, "R1");

      // R2: alternating directions with no gap, same and different words
      wr(10, "R2"); rdc(10, "R2"); wr(11, "R2"); rdc(3, "R2");
      rdc(11, "R2"); wr(11, "R2"); rdc(11, "R2"); wr(12, "R2");
      wr(13, "R2"); rdc(12, "R2"); rdc(13, "R2");

      // R3: plain read stream
      for (int i = 20; i < 24; i++) rdc(i, "R3");

      // R7: linear bursts from an unaligned start, then wrap past four beats
      lin = 1'b1;
      wr(22, "R7");
      for (int i = 0; i < 3; i++) drv(0, 1, 0, 0, 4'h0, SEL, "R7");
      drv(0, 0, 1, 21, 4'hF, SEL, "R7");
      for (int i = 0; i < 5; i++) drv(0, 1, 1, 0, 4'hF, SEL, "R7");

      // R8: interleaved bursts
      nop("R8");
      lin = 1'b0;
      wr(33, "R8");
      for (int i = 0; i < 3; i++) drv(0, 1, 0, 0, 4'h0, SEL, "R8");
      drv(0, 0, 1, 35, 4'hF, SEL, "R8");
      for (int i = 0; i < 3; i++) drv(0, 1, 1, 0, 4'hF, SEL, "R8");
      drv(0, 0, 1, 34, 4'hF, SEL, "R8");
      for (int i = 0; i < 3; i++) drv(0, 1, 1, 0, 4'hF, SEL, "R8");
      nop("R8");
      lin = 1'b1;

      // R9: advance cycles with flipped direction and deselected enables
      wr(44, "R9");
      drv(0, 1, 1, 9, 4'h0, 3'b110, "R9");
      drv(0, 1, 1, 9, 4'h0, 3'b000, "R9");
      drv(0, 1, 1, 9, 4'h0, 3'b011, "R9");
      drv(0, 0, 1, 44, 4'hF, SEL, "R9");
      drv(0, 1, 0, 9, 4'h0, 3'b110, "R9");
      drv(0, 1, 0, 9, 4'h0, 3'b011, "R9");
      drv(0, 1, 0, 9, 4'h0, SEL, "R9");

      // R5: each enable on its own blocks a load; issued transfer completes
      rdc(2, "R5"); drv(0, 0, 0, 2, 4'h0, 3'b110, "R5");
      rdc(3, "R5"); drv(0, 0, 0, 3, 4'h0, 3'b000, "R5");
      rdc(4, "R5"); drv(0, 0, 0, 4, 4'h0, 3'b011, "R5");
      wr(5, "R5");  drv(0, 0, 1, 5, 4'hF, 3'b110, "R5");
      rdc(5, "R5"); rdc(2, "R5"); rdc(3, "R5"); rdc(4, "R5");

      // R12: advance after a deselected load is inert
      drv(0, 0, 0, 6, 4'h0, 3'b011, "R12");
      drv(0, 1, 0, 6, 4'h0, SEL, "R12");
      drv(0, 1, 0, 6, 4'h0, SEL, "R12");
      rdc(6, "R12"); rdc(7, "R12");

      // R10: lane masks, bit i guards bits [9i+8:9i]
      wr(40, "R10");
      drv(0, 0, 0, 40, 4'b1010, SEL, "R10");
      drv(0, 0, 0, 41, 4'b0101, SEL, "R10");
      drv(0, 0, 0, 42, 4'b1111, SEL, "R10");
      drv(0, 0, 0, 43, 4'b0111, SEL, "R10");
      rdc(40, "R10"); rdc(41, "R10"); rdc(42, "R10"); rdc(43, "R10");

      // R4: stall during read phase, during write phase, and inside a burst
      rdc(8, "R4");
      drv(1, 0, 0, 8, 4'h0, SEL, "R4");
      drv(1, 0, 0, 9, 4'h0, SEL, "R4");
      wr(50, "R4");
      drv(1, 0, 0, 50, 4'h0, SEL, "R4");
      drv(1, 1, 0, 51, 4'h0, SEL, "R4");
      rdc(50, "R4"); rdc(51, "R4");
      drv(0, 0, 1, 52, 4'hF, SEL, "R4");
      drv(0, 1, 1, 0, 4'hF, SEL, "R4");
      drv(1, 0, 0, 60, 4'h0, SEL, "R4");
      drv(0, 1, 1, 0, 4'hF, SEL, "R4");
      drv(0, 1, 1, 0, 4'hF, SEL, "R4");
      rdc(60, "R4");

      // R11: output enable acts between clock edges
      rdc(30, "R11");
      keep = ref_mem[30];
      nop("R11");
      #1 oe_n = 1'b1;
      #1 chk(dq_oe === 1'b0, "R11", "drive off at once", {35'd0, dq_oe}, '0);
      oe_n = 1'b0;
      #1 chk(dq_oe === 1'b1, "R11", "drive back at once", {35'd0, dq_oe}, 36'd1);
      chk(dq_out === keep, "R11", "word intact", dq_out, keep);
      oe_n = 1'b1;
      rdc(31, "R11"); rdc(32, "R11");
      oe_n = 1'b0;
      rdc(31, "R11"); rdc(30, "R11");

      repeat (4) nop("R6");
      run = 0;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule